// File: doc/BRIEF.md
# Block-ID Memory Request Gate

This block sits beside a load/store queue and decides which pending memory operations may be handed to the memory pipeline. Each queued entry carries the program-block ID of the code region it belongs to. A moving throttle point, which is a block ID plus a throttle flag, comes from a path-confidence tracker. Every entry at or beyond that point is marked as stalled. While the flag is raised, stalled entries are removed from the issue pick, so speculative work far down a low-confidence path stops sending requests to memory.

Entries enter through a valid/ready allocation stream and land in the lowest free slot. The slot number is returned to the producer. Each slot has a per-entry ready input that signals its operands are available. Issue is a valid/ready stream that offers the oldest eligible entry by allocation order. An entry that has been issued stays in its slot until the owner frees it through the deallocation port. Block IDs wrap around, so comparisons use modular distance: an ID is at or beyond the throttle point when `(id - throttle) mod 2^W` lies in the lower half of the range.

Back-pressure rules:
- `alloc_ready` depends only on the queue's internal state.
- An allocation takes place in any cycle where both `alloc_valid` and `alloc_ready` are high.
- `issue_valid` and `issue_idx` are a combinational offer from the current state and `entry_ready`. They can change or drop while `issue_ready` is low, so the consumer must not rely on the offer holding stable.
- An issue takes place in any cycle where both `issue_valid` and `issue_ready` are high.

Top module: `blkid_mem_gate`

## Requirements
- R1: After reset no slot is occupied: `alloc_ready` is 1, `alloc_idx` is 0 and `issue_valid` is 0.
- R2: When `alloc_ready` is 1, `alloc_idx` shows the lowest-numbered free slot. An allocation occupies that slot. `alloc_ready` is 0 exactly when all DEPTH slots are occupied, and `alloc_valid` then has no effect.
- R3: A newly allocated entry takes its stall bit from the `thr_bid` and `thr_flag` presented in its allocation cycle. Its stall bit is 1 iff `(bid - thr_bid) mod 256 < 128`.
- R4: When the `thr_bid` or `thr_flag` input differs from the values registered at the previous edge, every occupied entry recomputes its stall bit. The stall bit is set if the entry's ID is at or beyond the new throttle ID by the wrap rule of R3.
- R5: In that same recomputation, entries whose ID is behind the throttle ID (distance 128 or more) get their stall bit cleared.
- R6: While the registered throttle flag is 1, which is the `thr_flag` value seen at the previous edge, a stalled entry is never offered on the issue port.
- R7: While the registered throttle flag is 0, stall bits have no influence on the issue offer.
- R8: Among eligible entries, the issue port offers the one allocated earliest. `issue_bid` is that entry's block ID. An entry is eligible when it is occupied, not yet issued, has `entry_ready` high and is not masked by R6.
- R9: After an issue handshake, the entry is not offered again until its slot is freed and reallocated.
- R10: `dealloc_en` frees slot `dealloc_idx` at the next edge, and it becomes allocatable again. Freeing a slot that is already free has no effect.
- R11: An entry whose `entry_ready` bit is 0 is not offered for issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thr_bid | input | BID_W | Throttle block ID |
| thr_flag | input | 1 | Throttle enable flag |
| alloc_valid | input | 1 | Allocation request |
| alloc_ready | output | 1 | A slot is free |
| alloc_bid | input | BID_W | Block ID of the entry being allocated |
| alloc_idx | output | IDX_W | Slot the allocation lands in |
| dealloc_en | input | 1 | Free a slot |
| dealloc_idx | input | IDX_W | Slot to free |
| entry_ready | input | DEPTH | Per-slot operand-ready bits |
| issue_valid | output | 1 | An entry is offered for issue |
| issue_ready | input | 1 | Memory pipeline accepts the offer |
| issue_idx | output | IDX_W | Slot offered for issue |
| issue_bid | output | BID_W | Block ID of the offered entry |

## Verification
The assertions rely on a few conditions about the inputs.
- `dealloc_idx` names a slot, and freeing is the only way a slot can leave the occupied state.
- `entry_ready` is sampled together with the offer at the same edge.
- The throttle inputs are stable for the whole cycle.

The stimulus changes every input only on the falling clock edge. It frees random slots, including slots that are already free, and it moves the throttle ID by small signed steps around a wandering point. This lets the allocated IDs sit on both sides of the throttle point and cross the 8-bit wrap. An exhaustive sweep covers all 256 modular distances between an entry ID and the throttle ID.

// File: rtl/mgate_pkg.sv
package mgate_pkg;

  localparam int unsigned MG_DEPTH = 16;
  localparam int unsigned MG_BID_W = 8;

  // Modular "at or beyond" test: the difference (id - point), taken modulo
  // 2^w, lies in the lower half of the ID space.
  function automatic logic bid_at_or_beyond(input logic [31:0] diff, input int unsigned msb);
    return ~diff[msb];
  endfunction

endpackage

// File: rtl/mgate_slot_alloc.sv
module mgate_slot_alloc #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] valid_vec,
  output logic             has_free,
  output logic [IDX_W-1:0] free_idx
);

  // Lowest-numbered free slot wins.
  always_comb begin
    has_free = 1'b0;
    free_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!valid_vec[i]) begin
        has_free = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/mgate_entry_bank.sv
module mgate_entry_bank
  import mgate_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned BID_W = 8,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              alloc_fire,
  input  logic [IDX_W-1:0]                  alloc_idx,
  input  logic [BID_W-1:0]                  alloc_bid,
  input  logic                              dealloc_en,
  input  logic [IDX_W-1:0]                  dealloc_idx,
  input  logic                              issue_fire,
  input  logic [IDX_W-1:0]                  issue_idx,
  input  logic [BID_W-1:0]                  thr_bid_in,
  input  logic                              thr_flag_in,
  output logic                              flag_q,
  output logic [DEPTH-1:0]                  valid_vec,
  output logic [DEPTH-1:0]                  issued_vec,
  output logic [DEPTH-1:0]                  stall_vec,
  output logic [DEPTH-1:0][BID_W-1:0]       bid_vec
);

  logic [BID_W-1:0] thr_q;
  logic             remark;
  logic [BID_W-1:0] new_diff;
  logic             new_stall;

  // Registered throttle point; any difference from the input is an update.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thr_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      thr_q  <= thr_bid_in;
      flag_q <= thr_flag_in;
    end
  end

  assign remark    = (thr_bid_in != thr_q) || (thr_flag_in != flag_q);
  assign new_diff  = alloc_bid - thr_bid_in;
  assign new_stall = bid_at_or_beyond(32'(new_diff), BID_W - 1);

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [BID_W-1:0] cur_diff;
    logic             cur_stall;
    logic             hit_alloc;
    logic             hit_free;
    logic             hit_issue;

    assign cur_diff  = bid_vec[g] - thr_bid_in;
    assign cur_stall = bid_at_or_beyond(32'(cur_diff), BID_W - 1);
    assign hit_alloc = alloc_fire && (alloc_idx == IDX_W'(g));
    assign hit_free  = dealloc_en && (dealloc_idx == IDX_W'(g));
    assign hit_issue = issue_fire && (issue_idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_vec[g]  <= 1'b0;
        issued_vec[g] <= 1'b0;
        stall_vec[g]  <= 1'b0;
        bid_vec[g]    <= '0;
      end else if (hit_alloc) begin
        valid_vec[g]  <= 1'b1;
        issued_vec[g] <= 1'b0;
        stall_vec[g]  <= new_stall;
        bid_vec[g]    <= alloc_bid;
      end else begin
        if (hit_free)  valid_vec[g]  <= 1'b0;
        if (hit_issue) issued_vec[g] <= 1'b1;
        if (remark && valid_vec[g]) stall_vec[g] <= cur_stall;
      end
    end
  end

  // R10
  dealloc_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dealloc_en && !(alloc_fire && alloc_idx == dealloc_idx)) |=> !valid_vec[$past(dealloc_idx)]);

  // R2
  alloc_occupies_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_fire |=> (valid_vec[$past(alloc_idx)] && !issued_vec[$past(alloc_idx)]));

endmodule

// File: rtl/mgate_age_pick.sv
module mgate_age_pick #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_fire,
  input  logic [IDX_W-1:0] alloc_idx,
  input  logic [DEPTH-1:0] elig_vec,
  output logic             pick_valid,
  output logic [IDX_W-1:0] pick_idx
);

  // older_q[j][i] set: slot j was allocated before slot i.
  logic [DEPTH-1:0] older_q [DEPTH];
  logic [DEPTH-1:0] grant;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int j = 0; j < DEPTH; j++) older_q[j] <= '0;
    end else if (alloc_fire) begin
      for (int j = 0; j < DEPTH; j++) begin
        older_q[j][alloc_idx] <= (IDX_W'(j) != alloc_idx);
      end
      for (int i = 0; i < DEPTH; i++) begin
        if (IDX_W'(i) != alloc_idx) older_q[alloc_idx][i] <= 1'b0;
      end
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_grant
    logic [DEPTH-1:0] beats_me;
    always_comb begin
      for (int j = 0; j < DEPTH; j++) beats_me[j] = older_q[j][g];
    end
    assign grant[g] = elig_vec[g] && ((elig_vec & beats_me) == '0);
  end

  always_comb begin
    pick_valid = |grant;
    pick_idx   = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (grant[i]) pick_idx = IDX_W'(i);
    end
  end

  // R8
  single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R8
  grant_when_any_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (elig_vec != '0) |-> pick_valid);

endmodule

// File: rtl/blkid_mem_gate.sv
module blkid_mem_gate
  import mgate_pkg::*;
#(
  parameter int unsigned DEPTH = MG_DEPTH,
  parameter int unsigned BID_W = MG_BID_W,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BID_W-1:0] thr_bid,
  input  logic             thr_flag,
  input  logic             alloc_valid,
  output logic             alloc_ready,
  input  logic [BID_W-1:0] alloc_bid,
  output logic [IDX_W-1:0] alloc_idx,
  input  logic             dealloc_en,
  input  logic [IDX_W-1:0] dealloc_idx,
  input  logic [DEPTH-1:0] entry_ready,
  output logic             issue_valid,
  input  logic             issue_ready,
  output logic [IDX_W-1:0] issue_idx,
  output logic [BID_W-1:0] issue_bid
);

  logic                        flag_q;
  logic [DEPTH-1:0]            valid_vec;
  logic [DEPTH-1:0]            issued_vec;
  logic [DEPTH-1:0]            stall_vec;
  logic [DEPTH-1:0][BID_W-1:0] bid_vec;
  logic [DEPTH-1:0]            elig_vec;
  logic                        alloc_fire;
  logic                        issue_fire;

  assign alloc_fire = alloc_valid && alloc_ready;
  assign issue_fire = issue_valid && issue_ready;

  mgate_slot_alloc #(.DEPTH(DEPTH)) u_alloc (
    .valid_vec (valid_vec),
    .has_free  (alloc_ready),
    .free_idx  (alloc_idx)
  );

  mgate_entry_bank #(.DEPTH(DEPTH), .BID_W(BID_W)) u_bank (
    .clk         (clk),
    .rst_n       (rst_n),
    .alloc_fire  (alloc_fire),
    .alloc_idx   (alloc_idx),
    .alloc_bid   (alloc_bid),
    .dealloc_en  (dealloc_en),
    .dealloc_idx (dealloc_idx),
    .issue_fire  (issue_fire),
    .issue_idx   (issue_idx),
    .thr_bid_in  (thr_bid),
    .thr_flag_in (thr_flag),
    .flag_q      (flag_q),
    .valid_vec   (valid_vec),
    .issued_vec  (issued_vec),
    .stall_vec   (stall_vec),
    .bid_vec     (bid_vec)
  );

  // Stall bits only gate the pick while the registered flag is raised.
  assign elig_vec = valid_vec & ~issued_vec & entry_ready
                  & ~({DEPTH{flag_q}} & stall_vec);

  mgate_age_pick #(.DEPTH(DEPTH)) u_pick (
    .clk        (clk),
    .rst_n      (rst_n),
    .alloc_fire (alloc_fire),
    .alloc_idx  (alloc_idx),
    .elig_vec   (elig_vec),
    .pick_valid (issue_valid),
    .pick_idx   (issue_idx)
  );

  assign issue_bid = bid_vec[issue_idx];

  // R6
  throttle_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && flag_q) |-> !stall_vec[issue_idx]);

  // R9
  no_reissue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_fire |=> !(issue_valid && issue_idx == $past(issue_idx)));

  // R11
  ready_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> entry_ready[issue_idx]);

  // R10
  free_after_dealloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dealloc_en && valid_vec[dealloc_idx]) |=> alloc_ready);

endmodule

// File: tb/sim_blkid_mem_gate.sv
module sim_blkid_mem_gate;

  localparam int D = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  thr_bid;
  logic        thr_flag;
  logic        alloc_valid;
  logic        alloc_ready;
  logic [7:0]  alloc_bid;
  logic [3:0]  alloc_idx;
  logic        dealloc_en;
  logic [3:0]  dealloc_idx;
  logic [15:0] entry_ready;
  logic        issue_valid;
  logic        issue_ready;
  logic [3:0]  issue_idx;
  logic [7:0]  issue_bid;

  always #2 clk = ~clk;

  blkid_mem_gate u0 (
    .clk(clk), .rst_n(rst_n), .thr_bid(thr_bid), .thr_flag(thr_flag),
    .alloc_valid(alloc_valid), .alloc_ready(alloc_ready), .alloc_bid(alloc_bid),
    .alloc_idx(alloc_idx), .dealloc_en(dealloc_en), .dealloc_idx(dealloc_idx),
    .entry_ready(entry_ready), .issue_valid(issue_valid), .issue_ready(issue_ready),
    .issue_idx(issue_idx), .issue_bid(issue_bid)
  );

  int checks = 0;
  int fails  = 0;

  bit       m_val [D];
  bit       m_iss [D];
  bit       m_stl [D];
  bit [7:0] m_bid [D];
  int       m_seq [D];
  int       seq_cnt = 0;
  bit [7:0] m_thr = 8'd0;
  bit       m_flg = 1'b0;

  function automatic bit ahead(input bit [7:0] id, input bit [7:0] pt);
    bit [7:0] d;
    d = id - pt;
    return d < 8'd128;
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Inputs are already driven (at a falling edge). Check, then advance the model.
  task automatic cycle(input string tag);
    int fr;
    int pk;
    bit a_f;
    bit i_f;
    bit evt;
    fr = -1;
    pk = -1;
    #1;
    for (int i = 0; i < D; i++) if (!m_val[i] && fr < 0) fr = i;
    chk(tag, "alloc_ready", int'(alloc_ready), int'(fr >= 0));
    if (fr >= 0) chk(tag, "alloc_idx", int'(alloc_idx), fr);
    for (int i = 0; i < D; i++) begin
      if (m_val[i] && !m_iss[i] && entry_ready[i] && !(m_flg && m_stl[i])) begin
        if (pk < 0 || m_seq[i] < m_seq[pk]) pk = i;
      end
    end
    chk(tag, "issue_valid", int'(issue_valid), int'(pk >= 0));
    if (pk >= 0) begin
      chk(tag, "issue_idx", int'(issue_idx), pk);
      chk(tag, "issue_bid", int'(issue_bid), int'(m_bid[pk]));
    end
    a_f = alloc_valid && (fr >= 0);
    i_f = (pk >= 0) && issue_ready;
    @(posedge clk);
    evt = (thr_bid != m_thr) || (thr_flag != m_flg);
    for (int i = 0; i < D; i++) if (evt && m_val[i]) m_stl[i] = ahead(m_bid[i], thr_bid);
    if (i_f) m_iss[pk] = 1'b1;
    if (dealloc_en) m_val[dealloc_idx] = 1'b0;
    if (a_f) begin
      m_val[fr] = 1'b1;
      m_iss[fr] = 1'b0;
      m_bid[fr] = alloc_bid;
      m_stl[fr] = ahead(alloc_bid, thr_bid);
      m_seq[fr] = seq_cnt;
      seq_cnt++;
    end
    m_thr = thr_bid;
    m_flg = thr_flag;
    @(negedge clk);
  endtask

  task automatic quiet();
    alloc_valid = 1'b0;
    dealloc_en  = 1'b0;
    issue_ready = 1'b0;
  endtask

  task automatic drain(input string tag);
    quiet();
    for (int s = 0; s < D; s++) begin
      dealloc_en  = 1'b1;
      dealloc_idx = 4'(s);
      cycle(tag);
    end
    dealloc_en = 1'b0;
  endtask

  // mode: 0 flag low, 1 flag high, 2 flag toggles
  task automatic rand_phase(input string tag, input int n, input int mode,
                            input int p_rdy, input int p_iss);
    for (int k = 0; k < n; k++) begin
      alloc_valid = ($urandom % 100) < 45;
      alloc_bid   = thr_bid + 8'($urandom % 64) - 8'd32;
      dealloc_en  = ($urandom % 100) < 30;
      dealloc_idx = 4'($urandom % 16);
      for (int b = 0; b < D; b++) entry_ready[b] = ($urandom % 100) < p_rdy;
      issue_ready = ($urandom % 100) < p_iss;
      if (($urandom % 100) < 20) thr_bid = thr_bid + 8'($urandom % 9) - 8'd4;
      if (($urandom % 512) == 0) thr_bid = thr_bid + 8'd120;
      if (mode == 0) thr_flag = 1'b0;
      else if (mode == 1) thr_flag = 1'b1;
      else if (($urandom % 100) < 10) thr_flag = ~thr_flag;
      cycle(tag);
    end
    quiet();
  endtask

  initial begin
    #(4 * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    thr_bid = 8'd0;
    thr_flag = 1'b0;
    alloc_bid = 8'd0;
    dealloc_idx = 4'd0;
    entry_ready = '1;
    quiet();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    #1;
    chk("R1", "alloc_ready", int'(alloc_ready), 1);
    chk("R1", "alloc_idx", int'(alloc_idx), 0);
    chk("R1", "issue_valid", int'(issue_valid), 0);
    @(negedge clk);

    // R2: fill beyond capacity, nothing ready
    entry_ready = '0;
    for (int k = 0; k < 20; k++) begin
      alloc_valid = 1'b1;
      alloc_bid = 8'(k * 3);
      cycle("R2");
    end
    quiet();

    // R10: free a slot, free it again, then reallocate
    dealloc_en = 1'b1; dealloc_idx = 4'd5; cycle("R10");
    dealloc_en = 1'b1; dealloc_idx = 4'd5; cycle("R10");
    dealloc_en = 1'b0; alloc_valid = 1'b1; alloc_bid = 8'd77; cycle("R10");
    quiet();
    entry_ready = '1; cycle("R10");

    // R3: every modular distance between entry ID and throttle ID
    drain("R3");
    thr_bid = 8'd100;
    thr_flag = 1'b1;
    entry_ready = '1;
    for (int d = 0; d < 256; d++) begin
      alloc_valid = 1'b1;
      alloc_bid = 8'(100 + d);
      cycle("R3");
      alloc_valid = 1'b0;
      cycle("R3");
      dealloc_en = 1'b1;
      dealloc_idx = 4'd0;
      cycle("R3");
      dealloc_en = 1'b0;
    end

    // R4 R5: full queue, sweep the throttle point, probe each slot alone
    drain("R4");
    thr_flag = 1'b1;
    entry_ready = '0;
    for (int s = 0; s < D; s++) begin
      alloc_valid = 1'b1;
      alloc_bid = 8'(s * 16 + 3);
      cycle("R4");
    end
    quiet();
    for (int t = 0; t < 256; t++) begin
      thr_bid = 8'(t);
      for (int s = 0; s < D; s++) begin
        entry_ready = 16'(1) << s;
        cycle((t % 2) == 0 ? "R4" : "R5");
      end
    end

    // R6 R7 R8 R9 R11: random traffic under several regimes
    drain("R6");
    rand_phase("R6", 3000, 1, 70, 60);
    drain("R7");
    rand_phase("R7", 3000, 0, 70, 60);
    rand_phase("R8", 3000, 2, 95, 40);
    rand_phase("R9", 3000, 2, 80, 95);
    rand_phase("R11", 3000, 2, 20, 70);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule